// File: doc/BRIEF.md
# Ping-Pong Audio Sample Buffer

This block is a dual-clock store of audio samples that sits between a fast card-side writer and a slow audio-rate reader. The writer fills words on its own clock through a plain write port. The reader walks through the store once per audio clock and presents one 16-bit sample per step. Play and stop inputs start and freeze the walk. A speed input sets how many entries the reader moves on each step.

The store is treated as two equal halves. The reader reports the half it is currently in. A copy of that flag, resynchronised into the write clock, lets the writer refill the idle half while the other half is being played. The reader always wraps from the last entry back to the first, so refilled data is picked up on the next pass.

Top module: `ppbuf_audio`

## Requirements
- R1: While `rst_n` is low, `sample` is 0, `playing` is 0, `rd_half` is 0 and `wr_rd_half` is 0, and the read position returns to entry 0. Store contents are not cleared.
- R2: On an `aud_clk` edge that samples `play` high and `stop` low, `playing` becomes 1 after that edge.
- R3: The read takes one cycle. On the first `aud_clk` edge after `playing` became 1, `sample` takes the word at the current read position.
- R4: On each `aud_clk` edge where `playing` is 1 and `stop` is low, `sample` takes the word at the current position and the position advances by `speed`. At speed 1 the words come out in address order, and at speed 0 the same entry repeats.
- R5: Position arithmetic is modulo 1024, so the reader moves from 1023 back to 0 (or to the entry reached past the end at larger speeds).
- R6: On an `aud_clk` edge that samples `stop` high, `playing` becomes 0 and both the position and `sample` stay unchanged. `stop` takes priority over `play`.
- R7: `rd_half` is bit 9 of the read position: 0 while the reader is in entries 0 to 511, and 1 while it is in entries 512 to 1023.
- R8: `wr_rd_half` is `rd_half` carried through two `wr_clk` flops.
- R9: A `wr_clk` edge with `wr_en` high stores `wr_data` at `wr_addr`. After a refill of the idle half, the reader plays the new words on its next pass.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Card-side write clock |
| aud_clk | input | 1 | Audio-rate read clock |
| rst_n | input | 1 | Asynchronous active-low reset, released per clock domain |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 10 | Write entry index |
| wr_data | input | 16 | Sample word to store |
| wr_rd_half | output | 1 | Reader half flag, synchronised to wr_clk |
| play | input | 1 | Start playback |
| stop | input | 1 | Freeze playback (wins over play) |
| speed | input | 4 | Entries advanced per audio clock |
| sample | output | 16 | Current output sample |
| playing | output | 1 | Playback active |
| rd_half | output | 1 | Half the reader is in (aud_clk domain) |

## Verification
The hardest case to reach is a refill racing the reader: the writer must rewrite one half while the reader is still in the other half. The reader must then cross the half boundary, wrap, and come back to play the new words. The stimulus reaches this with a separate writer process that waits on the synchronised half flag, rewrites the idle half, and waits for the flag to flip before rewriting the other half. Meanwhile the reader plays at speed 1 for more than a full lap. A reference model flags every sample taken from a refilled entry, so the check confirms that fresh data appears only after the reader has crossed into that half.

// File: rtl/ppbuf_pkg.sv
package ppbuf_pkg;
  localparam int unsigned PPB_ADDR_W  = 10;
  localparam int unsigned PPB_DATA_W  = 16;
  localparam int unsigned PPB_SPEED_W = 4;
  localparam int unsigned PPB_SYNC_N  = 2;
endpackage

// File: rtl/ppbuf_rstsync.sv
module ppbuf_rstsync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q, chain_d;

  always_comb chain_d = {chain_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/ppbuf_bitsync.sv
module ppbuf_bitsync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] stg_q, stg_d;

  always_comb stg_d = {stg_q[STAGES-2:0], d};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg_q <= '0;
    else        stg_q <= stg_d;
  end

  assign q = stg_q[STAGES-1];

  // R8: output follows the input delayed by the flop chain
  AST_SYNC_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
    $past(stg_q[STAGES-2]) == 1'b1 |-> q); // R8
endmodule

// File: rtl/ppbuf_mem.sv
module ppbuf_mem #(
  parameter int unsigned ADDR_W = 10,
  parameter int unsigned DATA_W = 16
) (
  input  logic              wr_clk,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_clk,
  input  logic              rd_rst_n,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_q
);
  localparam int unsigned DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] store [DEPTH];
  logic [DATA_W-1:0] q_nx;

  always_ff @(posedge wr_clk) begin
    if (wr_en) store[wr_addr] <= wr_data;
  end

  always_comb q_nx = rd_en ? store[rd_addr] : rd_q;

  always_ff @(posedge rd_clk or negedge rd_rst_n) begin
    if (!rd_rst_n) rd_q <= '0;
    else           rd_q <= q_nx;
  end

  // R6: output word frozen when no read is enabled
  AST_Q_HOLD: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    !rd_en |=> $stable(rd_q)); // R6
endmodule

// File: rtl/ppbuf_reader.sv
module ppbuf_reader #(
  parameter int unsigned ADDR_W  = 10,
  parameter int unsigned SPEED_W = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               play,
  input  logic               stop,
  input  logic [SPEED_W-1:0] speed,
  output logic               rd_en,
  output logic [ADDR_W-1:0]  rd_addr,
  output logic               playing,
  output logic               half
);
  logic              playing_nx;
  logic [ADDR_W-1:0] addr_nx;

  always_comb begin
    rd_en      = playing & ~stop;
    playing_nx = stop ? 1'b0 : (play ? 1'b1 : playing);
    addr_nx    = rd_en ? (rd_addr + ADDR_W'(speed)) : rd_addr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      playing <= 1'b0;
      rd_addr <= '0;
    end else begin
      playing <= playing_nx;
      rd_addr <= addr_nx;
    end
  end

  assign half = rd_addr[ADDR_W-1];

  AST_PLAY_RISES: assert property (@(posedge clk) disable iff (!rst_n)
    (play && !stop) |=> playing); // R2
  AST_STOP_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    stop |=> !playing); // R6
  AST_ADDR_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (!playing || stop) |=> $stable(rd_addr)); // R6
  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (playing && !stop && speed == SPEED_W'(1)) |=> rd_addr == ADDR_W'($past(rd_addr) + 1'b1)); // R4
endmodule

// File: rtl/ppbuf_audio.sv
module ppbuf_audio
  import ppbuf_pkg::*;
#(
  parameter int unsigned ADDR_W  = PPB_ADDR_W,
  parameter int unsigned DATA_W  = PPB_DATA_W,
  parameter int unsigned SPEED_W = PPB_SPEED_W,
  parameter int unsigned SYNC_N  = PPB_SYNC_N
) (
  input  logic               wr_clk,
  input  logic               aud_clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [ADDR_W-1:0]  wr_addr,
  input  logic [DATA_W-1:0]  wr_data,
  output logic               wr_rd_half,
  input  logic               play,
  input  logic               stop,
  input  logic [SPEED_W-1:0] speed,
  output logic [DATA_W-1:0]  sample,
  output logic               playing,
  output logic               rd_half
);
  logic              aud_rst_n, wr_rst_n, rd_en;
  logic [ADDR_W-1:0] rd_addr;

  ppbuf_rstsync #(.STAGES(SYNC_N)) u_rs_aud (
    .clk(aud_clk), .rst_n(rst_n), .rst_n_sync(aud_rst_n));
  ppbuf_rstsync #(.STAGES(SYNC_N)) u_rs_wr (
    .clk(wr_clk), .rst_n(rst_n), .rst_n_sync(wr_rst_n));

  ppbuf_reader #(.ADDR_W(ADDR_W), .SPEED_W(SPEED_W)) u_rd (
    .clk(aud_clk), .rst_n(aud_rst_n), .play(play), .stop(stop), .speed(speed),
    .rd_en(rd_en), .rd_addr(rd_addr), .playing(playing), .half(rd_half));

  ppbuf_mem #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mem (
    .wr_clk(wr_clk), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_clk(aud_clk), .rd_rst_n(aud_rst_n), .rd_en(rd_en), .rd_addr(rd_addr),
    .rd_q(sample));

  ppbuf_bitsync #(.STAGES(SYNC_N)) u_half_sync (
    .clk(wr_clk), .rst_n(wr_rst_n), .d(rd_half), .q(wr_rd_half));

  AST_RESET_CLEAR: assert property (@(posedge aud_clk)
    !aud_rst_n |-> (!playing && sample == '0 && !rd_half)); // R1
endmodule

// File: tb/sim_ppbuf_audio.sv
module sim_ppbuf_audio;
  logic        wr_clk = 1'b0, aud_clk = 1'b0, rst_n;
  logic        wr_en, play, stop;
  logic [9:0]  wr_addr;
  logic [15:0] wr_data, sample;
  logic [3:0]  speed;
  logic        wr_rd_half, playing, rd_half;

  ppbuf_audio u0 (.*);

  always #5 wr_clk = ~wr_clk;
  initial begin #3; forever #50 aud_clk = ~aud_clk; end

  int total = 0, bad = 0;
  logic [15:0] mem_m [1024];
  bit          refilled [1024];
  logic        m_playing, m_first, m_wrap;
  int          m_addr;
  logic [15:0] m_sample;
  string       s_tag, p_tag;
  bit          done = 0;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  always @(posedge wr_clk) if (wr_en) mem_m[wr_addr] = wr_data;

  always @(posedge aud_clk or negedge rst_n) begin
    if (!rst_n) begin
      m_playing = 0; m_addr = 0; m_sample = 0; m_first = 0; m_wrap = 0;
      s_tag = "R1"; p_tag = "R1";
    end else begin
      s_tag = "R4";
      if (m_playing && !stop) begin
        m_sample = mem_m[m_addr];
        if (refilled[m_addr])  s_tag = "R9";
        else if (m_wrap)       s_tag = "R5";
        else if (m_first)      s_tag = "R3";
        m_first = 0;
        m_wrap  = (m_addr + speed) >= 1024;
        m_addr  = (m_addr + speed) % 1024;
      end else if (stop) s_tag = "R6";
      p_tag = stop ? "R6" : "R2";
      if (stop) m_playing = 0;
      else if (play) begin
        if (!m_playing) m_first = 1;
        m_playing = 1;
      end
    end
  end

  always @(negedge aud_clk) if (rst_n && !done) begin
    chk(s_tag, sample, m_sample);
    chk(p_tag, playing, m_playing);
    chk("R7", rd_half, m_addr >= 512);
    chk("R8", wr_rd_half, m_addr >= 512);
  end

  task automatic aud_wait(int n);
    repeat (n) @(negedge aud_clk);
    #1;
  endtask

  task automatic write_word(int a, logic [15:0] d, bit mark);
    @(negedge wr_clk);
    wr_en = 1; wr_addr = a[9:0]; wr_data = d;
    refilled[a] = mark;
    @(negedge wr_clk);
    wr_en = 0;
  endtask

  int cyc = 0;
  always @(posedge wr_clk) begin
    cyc++;
    if (cyc > 190000) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 0; wr_en = 0; wr_addr = 0; wr_data = 0; play = 0; stop = 0; speed = 1;
    for (int i = 0; i < 1024; i++) refilled[i] = 0;
    aud_wait(3);
    chk("R1", sample, 0); chk("R1", playing, 0);
    chk("R1", rd_half, 0); chk("R1", wr_rd_half, 0);
    rst_n = 1;
    for (int i = 0; i < 1024; i++) write_word(i, 16'(i * 37 + 5) ^ 16'h5a00, 0);
    aud_wait(4);
    play = 1; aud_wait(1); play = 0;
    aud_wait(1100);
    stop = 1; aud_wait(5); stop = 0;
    aud_wait(5);
    speed = 3; play = 1; stop = 1; aud_wait(2);
    stop = 0; aud_wait(1); play = 0;
    aud_wait(400);
    speed = 0; aud_wait(6);
    speed = 15; aud_wait(150);
    stop = 1; aud_wait(2); stop = 0;
    rst_n = 0; aud_wait(3);
    chk("R1", sample, 0); chk("R1", playing, 0); chk("R1", rd_half, 0);
    rst_n = 1; aud_wait(4);
    speed = 1; play = 1; aud_wait(1); play = 0;
    fork
      aud_wait(1300);
      begin
        wait (wr_rd_half == 1'b1);
        for (int i = 0; i < 512; i++) write_word(i, 16'(i) ^ 16'hc3c3, 1);
        wait (wr_rd_half == 1'b0);
        for (int i = 512; i < 1024; i++) write_word(i, 16'(i) ^ 16'h3c3c, 1);
      end
    join
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule